// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns one accepted burst request into the column addresses a low-power double-data-rate memory expects for each data beat of that burst. A request carries a 9-bit starting column, a burst-length code and a wrap-order select taken from the captured mode-register value. The block then emits one address per clock, with a valid strobe and a flag on the final beat. Two transfers per memory clock are represented here as two consecutive beats.

The wrap window is the low part of the column: one bit for 2 beats, two bits for 4, three for 8 and four for 16. Within that window the offset either counts upward and wraps (sequential order) or is the start offset XOR the beat index (interleaved order). Bits above the window keep the starting value. A request made while a burst is running is dropped. A request carrying a reserved length code produces a one-cycle error pulse and no beats.

Top module: `burst_colgen`

## Requirements
- R1: While `rst_n` is low, `beat_valid`, `last_beat` and `cfg_err` are all 0.
- R2: A `start` sampled high on a rising edge while `beat_valid` is low, with `len_code` 3'b001, 3'b010, 3'b011 or 3'b100, gives exactly 2, 4, 8 or 16 beats. `beat_valid` is high from the cycle after that edge for that many consecutive cycles and then falls.
- R3: With `order_ilv` = 0, the low-window offset of beat i is (start offset + i) mod N, where N is the burst length and the window is col[log2 N - 1:0].
- R4: With `order_ilv` = 1, the low-window offset of beat i is start offset XOR i.
- R5: On every beat, the column bits above the wrap window equal those of `start_col`.
- R6: `last_beat` is high exactly on the final beat of a burst and never when `beat_valid` is low.
- R7: A `start` sampled while `beat_valid` is high is ignored. The running burst continues unchanged and no error is raised.
- R8: `len_code`, `order_ilv` and `start_col` are used only on the edge that accepts a burst. Changing them during a burst has no effect on its beats.
- R9: An accepted `start` with a reserved `len_code` (3'b000, 3'b101, 3'b110, 3'b111) drives `cfg_err` high for the one following cycle and produces no beats.
- R10: A 16-beat sequential burst starting at a column whose low four bits are 1 gives offsets 1, 2, ..., 15, then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Burst request strobe |
| start_col | input | 9 | Starting column of the burst |
| len_code | input | 3 | Burst length code: 1=2, 2=4, 3=8, 4=16 beats, others reserved |
| order_ilv | input | 1 | Wrap order: 0 sequential, 1 interleaved |
| col | output | 9 | Column address of the current beat |
| beat_valid | output | 1 | High while `col` carries a beat |
| last_beat | output | 1 | High on the final beat of a burst |
| cfg_err | output | 1 | One-cycle pulse after a request with a reserved length code |

## Verification
Beat 0 of an accepted burst is due in the cycle after the rising edge that samples `start`, and beat i is due i cycles later. The error pulse for a reserved code is due in that same first cycle and lasts one cycle. The bench model advances on the rising edge with the same accept rule, and all comparisons are made on the falling edge, half a period after the outputs settle. The directed 16-beat check reads the first beat on the falling edge right after the accepting edge and then reads one beat per falling edge.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int COL_W  = 9;
    localparam int IDX_W  = 4;
    localparam int CODE_W = 3;

    typedef struct packed {
        logic             busy;
        logic [COL_W-1:0] base;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] last_idx;
        logic             ilv;
        logic             err;
    } seq_state_t;

endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode #(
    parameter int IDX_W  = 4,
    parameter int CODE_W = 3
) (
    input  logic [CODE_W-1:0] code,
    output logic              ok,
    output logic [IDX_W-1:0]  last_idx
);
    always_comb begin
        ok       = 1'b0;
        last_idx = '0;
        for (int k = 1; k <= IDX_W; k++) begin
            if (code == CODE_W'(k)) begin
                ok       = 1'b1;
                last_idx = IDX_W'((1 << k) - 1);
            end
        end
    end
endmodule

// File: rtl/burst_offset_calc.sv
module burst_offset_calc #(
    parameter int COL_W = 9,
    parameter int IDX_W = 4
) (
    input  logic [COL_W-1:0] base,
    input  logic [IDX_W-1:0] idx,
    input  logic [IDX_W-1:0] mask,
    input  logic             ilv,
    output logic [COL_W-1:0] col
);
    logic [IDX_W-1:0] low;
    logic [IDX_W-1:0] seq_off;
    logic [IDX_W-1:0] ilv_off;
    logic [IDX_W-1:0] off;

    always_comb begin
        low     = base[IDX_W-1:0];
        seq_off = (low + idx) & mask;
        ilv_off = (low ^ idx) & mask;
        off     = ilv ? ilv_off : seq_off;
        col     = {base[COL_W-1:IDX_W], (low & ~mask) | off};
    end
endmodule

// File: rtl/burst_colgen.sv
module burst_colgen
    import burst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [COL_W-1:0]  start_col,
    input  logic [CODE_W-1:0] len_code,
    input  logic              order_ilv,
    output logic [COL_W-1:0]  col,
    output logic              beat_valid,
    output logic              last_beat,
    output logic              cfg_err
);
    seq_state_t       s_d, s_q;
    logic             dec_ok;
    logic [IDX_W-1:0] dec_last;

    burst_len_decode #(.IDX_W(IDX_W), .CODE_W(CODE_W)) u_dec (
        .code     (len_code),
        .ok       (dec_ok),
        .last_idx (dec_last)
    );

    burst_offset_calc #(.COL_W(COL_W), .IDX_W(IDX_W)) u_off (
        .base (s_q.base),
        .idx  (s_q.idx),
        .mask (s_q.last_idx),
        .ilv  (s_q.ilv),
        .col  (col)
    );

    always_comb begin
        s_d     = s_q;
        s_d.err = 1'b0;
        if (s_q.busy) begin
            if (s_q.idx == s_q.last_idx) begin
                s_d.busy = 1'b0;
            end else begin
                s_d.idx = s_q.idx + 1'b1;
            end
        end else if (start) begin
            if (dec_ok) begin
                s_d.busy     = 1'b1;
                s_d.base     = start_col;
                s_d.idx      = '0;
                s_d.last_idx = dec_last;
                s_d.ilv      = order_ilv;
            end else begin
                s_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign beat_valid = s_q.busy;
    assign last_beat  = s_q.busy && (s_q.idx == s_q.last_idx);
    assign cfg_err    = s_q.err;

endmodule

// File: rtl/burst_colgen_chk.sv
module burst_colgen_chk #(
    parameter int COL_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [COL_W-1:0] col,
    input logic             beat_valid,
    input logic             last_beat,
    input logic             cfg_err
);
    assert_last_in_burst_R6: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat |-> beat_valid);

    assert_end_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat |=> !beat_valid);

    assert_no_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !last_beat) |=> beat_valid);

    assert_upper_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !last_beat) |=> $stable(col[COL_W-1:4]));

    assert_err_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !beat_valid);

    assert_busy_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !last_beat && start) |=> (beat_valid && !cfg_err));

endmodule

bind burst_colgen burst_colgen_chk #(.COL_W(burst_pkg::COL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .col        (col),
    .beat_valid (beat_valid),
    .last_beat  (last_beat),
    .cfg_err    (cfg_err)
);

// File: tb/sim_burst_colgen.sv
`timescale 1ns/1ps
module sim_burst_colgen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [8:0] start_col = '0;
    logic [2:0] len_code = 3'd1;
    logic       order_ilv = 1'b0;
    logic [8:0] col;
    logic       beat_valid, last_beat, cfg_err;

    int    n_chk = 0;
    int    n_fail = 0;
    string cur_req = "R1";
    bit    done = 0;

    typedef struct { int c; bit last; } beat_t;
    beat_t q[$];
    bit    exp_err = 0;

    always #2 clk = ~clk;

    burst_colgen u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
        .len_code(len_code), .order_ilv(order_ilv), .col(col),
        .beat_valid(beat_valid), .last_beat(last_beat), .cfg_err(cfg_err)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference model: beats follow from the requirement formulas.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.delete();
            exp_err = 0;
        end else begin
            bit was_busy;
            was_busy = (q.size() != 0);
            if (was_busy) void'(q.pop_front());
            exp_err = 0;
            if (start && !was_busy) begin
                if (len_code >= 3'd1 && len_code <= 3'd4) begin
                    int n, off, base;
                    n    = 1 << len_code;
                    off  = start_col % n;
                    base = start_col - off;
                    for (int i = 0; i < n; i++) begin
                        beat_t b;
                        b.c    = base + (order_ilv ? (off ^ i) : ((off + i) % n));
                        b.last = (i == n - 1);
                        q.push_back(b);
                    end
                end else begin
                    exp_err = 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check({"R2 beat_valid"}, beat_valid, q.size() != 0);
            check({"R9 cfg_err"}, cfg_err, exp_err);
            if (q.size() != 0) begin
                check({cur_req, " col"}, col, q[0].c);
                check({"R6 last_beat"}, last_beat, q[0].last);
            end else begin
                check({"R6 last_beat idle"}, last_beat, 0);
            end
        end
    end

    task automatic go(int c, int code, bit ilv, string req);
        @(negedge clk);
        cur_req   = req;
        start_col = 9'(c);
        len_code  = 3'(code);
        order_ilv = ilv;
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (18) @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 beat_valid", beat_valid, 0);
        check("R1 last_beat", last_beat, 0);
        check("R1 cfg_err", cfg_err, 0);
        rst_n = 1'b1;

        go(9'h003, 1, 0, "R2");
        go(9'h046, 2, 0, "R2");
        go(9'h10B, 3, 0, "R2");
        go(9'h0A6, 3, 0, "R3");
        go(9'h0A7, 2, 0, "R3");
        go(9'h035, 2, 1, "R4");
        go(9'h0C5, 3, 1, "R4");
        go(9'h13A, 4, 1, "R4");
        go(9'h1FE, 2, 0, "R5");
        go(9'h1F7, 3, 1, "R5");

        // R7: second request mid-burst is dropped
        @(negedge clk);
        cur_req = "R7"; start_col = 9'h021; len_code = 3'd3; order_ilv = 0; start = 1;
        @(negedge clk); start = 0;
        repeat (2) @(negedge clk);
        start_col = 9'h1C4; len_code = 3'd0; start = 1;
        @(negedge clk);
        start_col = 9'h0F2; len_code = 3'd2;
        @(negedge clk); start = 0;
        repeat (16) @(negedge clk);

        // R8: configuration changes during a burst have no effect
        @(negedge clk);
        cur_req = "R8"; start_col = 9'h08D; len_code = 3'd4; order_ilv = 0; start = 1;
        @(negedge clk); start = 0;
        @(negedge clk); len_code = 3'd1; order_ilv = 1; start_col = 9'h1FF;
        repeat (18) @(negedge clk);

        // R9: reserved codes
        go(9'h010, 0, 0, "R9");
        go(9'h010, 5, 0, "R9");
        go(9'h010, 6, 1, "R9");
        go(9'h010, 7, 0, "R9");

        // R10: directed 16-beat sequential from offset 1
        @(negedge clk);
        cur_req = "R10"; start_col = 9'h1F1; len_code = 3'd4; order_ilv = 0; start = 1;
        @(negedge clk); start = 0;
        for (int i = 0; i < 16; i++) begin
            check("R10 col", col, 9'h1F0 | ((i + 1) % 16));
            check("R10 last", last_beat, i == 15);
            @(negedge clk);
        end
        repeat (3) @(negedge clk);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule